// File: doc/BRIEF.md
# Vector Bitwise Test Flag Unit

This block produces condition flags for a packed-integer bit test on two vector operands. The register operand is called A and the second operand, from a register or from memory, is called B. The block checks whether A AND B is all zeros and whether B AND NOT A is all zeros. It works over 128 bits or 256 bits. The two reductions run side by side, so each operation costs one registered stage. The block never writes a data result: A passes through unchanged and there is no data output.

An operation is presented with `in_valid`. Its flags appear one clock later with `out_valid`. The first request is a VEX-encoded operation whose 4-bit extra-register field is anything other than all ones. The second is a 256-bit request in the legacy encoding. Either one traps instead: `ud` is raised and the held flags keep their previous values.

The controller is a three-state machine:
- `ST_IDLE` means no result is presented.
- `ST_FLAGS` means a flag update is presented.
- `ST_TRAP` means an invalid-opcode result is presented.

Its transitions are:
- `GO_IDLE` is taken whenever `in_valid` is low.
- `GO_FLAGS` is taken on a valid request that passes the encoding check.
- `GO_TRAP` is taken on a valid request that fails the encoding check.

Each transition can be taken from any state.

Top module: `vtest_flag_unit`

## Requirements
- R1: One cycle after an accepted request, `zf_out` is 1 exactly when A AND B is zero over the active width, and 0 otherwise.
- R2: One cycle after an accepted request, `cf_out` is 1 exactly when B AND NOT A is zero over the active width, and 0 otherwise.
- R3: `of_out`, `af_out`, `pf_out` and `sf_out` are 0 at all times.
- R4: With `wide`=0, bits 255:128 of both `src_a` and `src_b` have no effect on any flag.
- R5: With `wide`=1 and `is_vex`=1, all 256 bits take part in both reductions.
- R6: A request with `is_vex`=1 and `vvvv`≠4'b1111 gives `ud`=1 one cycle later. `zf_out`, `cf_out` and `mixed_out` then keep their previous values.
- R7: With `is_vex`=0, `vvvv` is ignored. A request with `is_vex`=0 and `wide`=1 traps with `ud`=1, and the flags are held.
- R8: `out_valid` is 1 in the cycle after every cycle with `in_valid`=1, and 0 in the cycle after every cycle with `in_valid`=0. `ud` is 0 whenever `out_valid` is 0.
- R9: `mixed_out` is 1 exactly when both `zf_out` and `cf_out` were computed as 0 by the last accepted request.
- R10: Synchronous active-high `rst` clears `out_valid`, `ud`, `zf_out`, `cf_out` and `mixed_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; the operands are sampled when it is high |
| is_vex | input | 1 | 1 = VEX encoding, 0 = legacy encoding |
| wide | input | 1 | 1 = 256-bit width, 0 = 128-bit width |
| vvvv | input | 4 | Extra-register field; must be 4'b1111 for VEX |
| src_a | input | 256 | Register operand A |
| src_b | input | 256 | Second operand B (register or memory) |
| out_valid | output | 1 | A result is presented this cycle |
| zf_out | output | 1 | Zero flag |
| cf_out | output | 1 | Carry flag |
| of_out | output | 1 | Overflow flag (always 0) |
| af_out | output | 1 | Auxiliary-carry flag (always 0) |
| pf_out | output | 1 | Parity flag (always 0) |
| sf_out | output | 1 | Sign flag (always 0) |
| mixed_out | output | 1 | 1 when the zero and carry flags are both 0 |
| ud | output | 1 | Invalid-opcode indication |

## Verification
A trap and the holding of the flags fall in the same cycle. That cycle's result must show `ud` while the flag outputs still show what the previous accepted request produced. The bench provokes this with back-to-back requests, where a trapping request directly follows an accepted one. The trapping requests use either a bad extra-register field or a wide legacy request, and some have operands that would flip every flag if they were used. A bench model updates its flags only on accepted requests and compares every field on every result cycle, so a trap that leaks into the flags is caught.

// File: rtl/vtest_pkg.sv
package vtest_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLAGS = 2'd1,
        ST_TRAP  = 2'd2
    } vt_state_e;

    localparam logic [3:0] VT_RSVD_OK = 4'b1111;

    typedef struct packed {
        logic zf;
        logic cf;
        logic mixed;
    } vt_flags_t;
endpackage

// File: rtl/vtest_lane_reduce.sv
module vtest_lane_reduce #(
    parameter int LANE_W  = 128,
    parameter int CHUNK_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic              and_any,
    output logic              andn_any
);
    localparam int CHUNKS = LANE_W / CHUNK_W;

    logic [CHUNKS-1:0] and_part;
    logic [CHUNKS-1:0] andn_part;

    // Two-level OR tree: per-chunk reduction, then across chunks.
    for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
        logic [CHUNK_W-1:0] a_c;
        logic [CHUNK_W-1:0] b_c;
        assign a_c = a[c*CHUNK_W +: CHUNK_W];
        assign b_c = b[c*CHUNK_W +: CHUNK_W];
        assign and_part[c]  = |(a_c & b_c);
        assign andn_part[c] = |(b_c & ~a_c);
    end

    assign and_any  = |and_part;
    assign andn_any = |andn_part;
endmodule

// File: rtl/vtest_reduce.sv
module vtest_reduce #(
    parameter int DATA_W   = 256,
    parameter int NARROW_W = 128,
    parameter int CHUNK_W  = 32
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              zf_calc,
    output logic              cf_calc
);
    localparam int LANES = DATA_W / NARROW_W;

    logic [LANES-1:0] lane_and;
    logic [LANES-1:0] lane_andn;
    logic [LANES-1:0] lane_en;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane 0 is always active; the upper lanes only in the wide form.
        if (l == 0) begin : g_base
            assign lane_en[l] = 1'b1;
        end else begin : g_upper
            assign lane_en[l] = wide;
        end

        vtest_lane_reduce #(
            .LANE_W (NARROW_W),
            .CHUNK_W(CHUNK_W)
        ) u_lane (
            .a       (a[l*NARROW_W +: NARROW_W]),
            .b       (b[l*NARROW_W +: NARROW_W]),
            .and_any (lane_and[l]),
            .andn_any(lane_andn[l])
        );
    end

    assign zf_calc = ~|(lane_and  & lane_en);
    assign cf_calc = ~|(lane_andn & lane_en);
endmodule

// File: rtl/vtest_encode_chk.sv
module vtest_encode_chk (
    input  logic       is_vex,
    input  logic       wide,
    input  logic [3:0] vvvv,
    output logic       trap
);
    import vtest_pkg::*;

    logic rsvd_bad;
    logic legacy_wide;

    assign rsvd_bad    = is_vex && (vvvv != VT_RSVD_OK);
    assign legacy_wide = !is_vex && wide;
    assign trap        = rsvd_bad || legacy_wide;
endmodule

// File: rtl/vtest_ctrl.sv
module vtest_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic trap,
    input  logic zf_calc,
    input  logic cf_calc,
    output logic out_valid,
    output logic ud,
    output logic zf_out,
    output logic cf_out,
    output logic mixed_out
);
    import vtest_pkg::*;

    vt_state_e state_q;
    vt_state_e state_d;
    vt_flags_t flags_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case ({in_valid, trap})
            2'b10:   state_d = ST_FLAGS;
            2'b11:   state_d = ST_TRAP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (state_d == ST_FLAGS) begin
            flags_q.zf    <= zf_calc;
            flags_q.cf    <= cf_calc;
            flags_q.mixed <= !zf_calc && !cf_calc;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        ud        = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin out_valid = 1'b0; ud = 1'b0; end
            ST_FLAGS: begin out_valid = 1'b1; ud = 1'b0; end
            ST_TRAP:  begin out_valid = 1'b1; ud = 1'b1; end
            default:  begin out_valid = 1'b0; ud = 1'b0; end
        endcase
        zf_out    = flags_q.zf;
        cf_out    = flags_q.cf;
        mixed_out = flags_q.mixed;
    end

    p_trap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ud |-> ($stable(zf_out) && $stable(cf_out) && $stable(mixed_out)));
    p_mixed_excl_r9: assert property (@(posedge clk) disable iff (rst)
        mixed_out |-> (!zf_out && !cf_out));
    p_ud_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
        ud |-> out_valid);
endmodule

// File: rtl/vtest_flag_unit.sv
module vtest_flag_unit #(
    parameter int DATA_W   = 256,
    parameter int NARROW_W = 128,
    parameter int CHUNK_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              is_vex,
    input  logic              wide,
    input  logic [3:0]        vvvv,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic              zf_out,
    output logic              cf_out,
    output logic              of_out,
    output logic              af_out,
    output logic              pf_out,
    output logic              sf_out,
    output logic              mixed_out,
    output logic              ud
);
    logic zf_calc;
    logic cf_calc;
    logic trap;

    vtest_reduce #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W),
        .CHUNK_W (CHUNK_W)
    ) u_reduce (
        .wide   (wide),
        .a      (src_a),
        .b      (src_b),
        .zf_calc(zf_calc),
        .cf_calc(cf_calc)
    );

    vtest_encode_chk u_enc (
        .is_vex(is_vex),
        .wide  (wide),
        .vvvv  (vvvv),
        .trap  (trap)
    );

    vtest_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .trap     (trap),
        .zf_calc  (zf_calc),
        .cf_calc  (cf_calc),
        .out_valid(out_valid),
        .ud       (ud),
        .zf_out   (zf_out),
        .cf_out   (cf_out),
        .mixed_out(mixed_out)
    );

    // The remaining status flags are always cleared by this operation.
    assign of_out = 1'b0;
    assign af_out = 1'b0;
    assign pf_out = 1'b0;
    assign sf_out = 1'b0;

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_vex_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_vex && (vvvv != 4'b1111)) |=> ud);
    p_legacy_wide_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_vex && wide) |=> ud);
    p_good_no_ud_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((is_vex && vvvv == 4'b1111) || (!is_vex && !wide))) |=> !ud);
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && !ud && !zf_out && !cf_out && !mixed_out));
endmodule

// File: tb/vtest_flag_unit_test.sv
`timescale 1ns/1ps
module vtest_flag_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         is_vex;
    logic         wide;
    logic [3:0]   vvvv;
    logic [255:0] src_a;
    logic [255:0] src_b;
    logic out_valid, zf_out, cf_out, of_out, af_out, pf_out, sf_out, mixed_out, ud;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state: flags of the last accepted request
    logic m_zf = 0, m_cf = 0, m_mix = 0;

    always #10 clk = ~clk;

    vtest_flag_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .is_vex(is_vex), .wide(wide),
        .vvvv(vvvv), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .zf_out(zf_out), .cf_out(cf_out), .of_out(of_out), .af_out(af_out),
        .pf_out(pf_out), .sf_out(sf_out), .mixed_out(mixed_out), .ud(ud)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] act_mask(input logic w);
        return w ? {256{1'b1}} : {128'd0, {128{1'b1}}};
    endfunction

    // drive at negedge, check at next negedge (one posedge later)
    task automatic op(input logic vx, input logic w, input logic [3:0] f,
                      input logic [255:0] a, input logic [255:0] b, input string tag);
        logic trap;
        logic ezf, ecf;
        in_valid = 1'b1; is_vex = vx; wide = w; vvvv = f; src_a = a; src_b = b;
        trap = (vx && f != 4'b1111) || (!vx && w);
        ezf = ((a & b & act_mask(w)) == '0);
        ecf = ((b & ~a & act_mask(w)) == '0);
        if (!trap) begin
            m_zf = ezf; m_cf = ecf; m_mix = !ezf && !ecf;
        end
        @(negedge clk);
        chk(out_valid, 1'b1, {tag, " R8 out_valid"});
        chk(ud, trap, {tag, vx ? " R6 ud" : " R7 ud"});
        chk(zf_out, m_zf, {tag, w ? " R5 zf" : " R1 zf"});
        chk(cf_out, m_cf, {tag, w ? " R5 cf" : " R2 cf"});
        chk(mixed_out, m_mix, {tag, " R9 mixed"});
        chk(of_out | af_out | pf_out | sf_out, 1'b0, {tag, " R3 cleared"});
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid, 1'b0, {tag, " R8 idle out_valid"});
        chk(ud, 1'b0, {tag, " R8 idle ud"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [255:0] ones;
        logic [255:0] hi_only;
        logic [255:0] ra, rb;
        void'($urandom(32'h5eed_1234));
        ones = {256{1'b1}};
        hi_only = {{128{1'b1}}, 128'd0};
        rst = 1'b1; in_valid = 0; is_vex = 0; wide = 0; vvvv = 0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid, 1'b0, "R10 out_valid");
        chk(ud, 1'b0, "R10 ud");
        chk(zf_out, 1'b0, "R10 zf");
        chk(cf_out, 1'b0, "R10 cf");
        chk(mixed_out, 1'b0, "R10 mixed");
        rst = 1'b0;
        idle("R8 post-reset");

        // directed corners
        op(1, 0, 4'hF, '0, '0, "R1 zeros");
        op(0, 0, 4'h3, ones, ones, "R7 legacy ignores vvvv");
        op(1, 0, 4'hF, {128'd0, 128'h1}, {128'd0, 128'h2}, "R9 mixed one-hot");
        // R4: upper halves set, narrow -> both flags 1
        op(1, 0, 4'hF, hi_only, hi_only, "R4 narrow ignore");
        op(0, 0, 4'hF, ~hi_only & 256'h0, hi_only, "R4 narrow legacy");
        // R5: only upper bits differ, wide sees them
        op(1, 1, 4'hF, hi_only, hi_only, "R5 wide and");
        op(1, 1, 4'hF, '0, hi_only, "R5 wide andn");
        // back-to-back trap right after an update: flags hold
        op(1, 0, 4'hF, {128'd0, 128'h1}, {128'd0, 128'h3}, "R9 setup");
        op(1, 0, 4'hE, '0, '0, "R6 trap hold");
        op(0, 1, 4'hF, ones, '0, "R7 legacy wide trap");
        op(1, 1, 4'h0, ones, ones, "R6 trap wide");
        idle("R8 gap");
        // reset clears after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_zf = 0; m_cf = 0; m_mix = 0;
        chk(zf_out, 1'b0, "R10 zf after use");
        chk(out_valid, 1'b0, "R10 valid after use");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic vx, w;
            logic [3:0] f;
            ra = rnd256();
            rb = rnd256();
            case ($urandom % 4)
                0: rb = rb & ~ra;          // zf likely 1
                1: rb = rb & ra;           // cf likely 1
                2: rb = rb & {8{$urandom}} & {8{$urandom}};
                default: ;
            endcase
            vx = ($urandom % 4) != 0;
            w  = $urandom % 2;
            f  = (($urandom % 5) == 0) ? 4'($urandom) : 4'hF;
            op(vx, w, f, ra, rb, "rand");
            if (($urandom % 6) == 0) idle("R8 rand idle");
        end
        idle("R8 end");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule